// File: doc/BRIEF.md
# Interrupt Claim/Complete Priority Arbiter

This block is the selection stage of one interrupt target inside a platform interrupt controller. Every cycle it looks at the pending and enable state of up to `NSRC` sources, their priorities and the target's threshold. From these it picks one source that may be claimed and drives a registered interrupt request to the target. Sources are numbered 1 to `NSRC`. ID 0 means "no source".

Software claims an interrupt with a one-cycle `claim_req` pulse, which is the register read. One cycle later the block returns the winning ID on a response channel that has a valid flag. In the same clock edge it marks that source as claimed. A claimed source stays out of arbitration until software completes it with a `cmpl_req` pulse that carries its ID. The response channel has no ready signal, so a response can never be stalled. It is valid for exactly one cycle and the consumer must take it then. Address decoding and the tracking of source levels happen outside this block.

Vector bit `i` and priority field `src_prio[PW*i +: PW]` both belong to source ID `i+1`.

Top module: `irq_claim_arbiter`

## Requirements
- R1: A source is a candidate only when it is pending, enabled, not claimed, and its priority is strictly greater than `ctx_thresh`. A priority of 0 therefore never interrupts.
- R2: Among the candidates, the source with the highest priority wins. When several candidates share that priority, the lowest ID wins.
- R3: A `claim_req` pulse in cycle t gives `claim_rsp_valid` high in cycle t+1, with `claim_rsp_id` equal to the winner in cycle t, or 0 when there was no candidate. `claim_rsp_valid` is low in every cycle that does not follow a claim.
- R4: The claim marks the returned source as claimed in the same edge that registers the response. Repeated claims therefore return the next-best source each time, and then 0.
- R5: A `cmpl_req` pulse releases a source only when `cmpl_id` is between 1 and `NSRC` and that source is enabled at that moment. In any other case the complete has no effect.
- R6: A claimed source stays claimed while it is disabled. Enabling it again does not make it a candidate until it is completed.
- R7: `irq` is registered. It is high exactly in the cycle after one in which a candidate existed, so any change to pending, enable, priority, threshold or claim state shows on `irq` after one clock.
- R8: A claim and a complete in the same cycle both take effect.
- R9: After reset no source is claimed, and `irq` and `claim_rsp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend | input | NSRC | Pending flag per source (bit i = ID i+1) |
| src_en | input | NSRC | Enable per source for this target |
| src_prio | input | NSRC*PW | Priority per source, PW bits each |
| ctx_thresh | input | PW | Target threshold |
| claim_req | input | 1 | One-cycle claim strobe |
| claim_rsp_valid | output | 1 | Claim response valid (one cycle) |
| claim_rsp_id | output | IDW | Claimed ID, 0 if none |
| cmpl_req | input | 1 | One-cycle complete strobe |
| cmpl_id | input | IDW | ID being completed |
| irq | output | 1 | Registered interrupt request to the target |

## Verification
The claimed vector can only be observed indirectly. A bit that is wrongly set makes a source vanish from later claims and can hold `irq` low. A bit that is wrongly clear shows up as the same ID being returned twice. Both effects appear in the response one cycle after the next claim, or on `irq` one clock after the state changes. An error in the tree's compare order shows up at once as the wrong ID in a tie or in a mixed-priority claim. The tests therefore follow each claim, complete or enable change with further claims and `irq` samples.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Right-hand contender replaces the left one only on strictly higher
  // priority; the left subtree always holds the lower IDs, so ties go left.
  function automatic logic right_wins(input logic l_vld, input logic [7:0] l_prio,
                                      input logic r_vld, input logic [7:0] r_prio);
    return r_vld && (!l_vld || (r_prio > l_prio));
  endfunction

endpackage

// File: rtl/irq_arb_tree.sv
module irq_arb_tree
  import irq_arb_pkg::*;
#(
  parameter int NSRC = 31,
  parameter int PW   = 4,
  parameter int IDW  = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]    cand,
  input  logic [NSRC*PW-1:0] prio,
  output logic               win_vld,
  output logic [IDW-1:0]     win_id,
  output logic [PW-1:0]      win_prio
);
  localparam int LEAVES = 1 << $clog2(NSRC + 1);
  localparam int NODES  = 2 * LEAVES;

  logic           nv [1:NODES-1];
  logic [PW-1:0]  np [1:NODES-1];
  logic [IDW-1:0] ni [1:NODES-1];

  // Leaf j carries source ID j; leaf 0 and padding leaves never win.
  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j >= 1 && j <= NSRC) begin : g_real
      assign nv[LEAVES+j] = cand[j-1];
      assign np[LEAVES+j] = prio[(j-1)*PW +: PW];
      assign ni[LEAVES+j] = IDW'(j);
    end else begin : g_pad
      assign nv[LEAVES+j] = 1'b0;
      assign np[LEAVES+j] = '0;
      assign ni[LEAVES+j] = '0;
    end
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    logic take_r;
    assign take_r = right_wins(nv[2*k], 8'(np[2*k]), nv[2*k+1], 8'(np[2*k+1]));
    assign nv[k]  = nv[2*k] | nv[2*k+1];
    assign np[k]  = take_r ? np[2*k+1] : np[2*k];
    assign ni[k]  = take_r ? ni[2*k+1] : (nv[2*k] ? ni[2*k] : '0);
  end

  assign win_vld  = nv[1];
  assign win_id   = nv[1] ? ni[1] : '0;
  assign win_prio = np[1];

endmodule

// File: rtl/irq_claim_track.sv
module irq_claim_track #(
  parameter int NSRC = 31,
  parameter int IDW  = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            claim_req,
  input  logic [IDW-1:0]  win_id,
  input  logic            cmpl_req,
  input  logic [IDW-1:0]  cmpl_id,
  input  logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] claimed_q,
  output logic            rsp_valid,
  output logic [IDW-1:0]  rsp_id
);
  logic [NSRC-1:0] set_m, clr_m;

  // The same winner drives both the response and the set mask (atomic claim).
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      set_m[i] = claim_req && (win_id == IDW'(i + 1));
      clr_m[i] = cmpl_req  && (cmpl_id == IDW'(i + 1)) && src_en[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claimed_q <= '0;
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
    end else begin
      claimed_q <= (claimed_q & ~clr_m) | set_m;
      rsp_valid <= claim_req;
      rsp_id    <= claim_req ? win_id : '0;
    end
  end

  a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    claim_req |=> rsp_valid);
  a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !claim_req |=> !rsp_valid);
  a_r4_rsp_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_id != '0) |-> claimed_q[rsp_id - IDW'(1)]);

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    a_r5_release_legal: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(claimed_q[i]) |-> $past(cmpl_req && cmpl_id == IDW'(i + 1) && src_en[i]));
    a_r4_set_by_claim: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(claimed_q[i]) |-> $past(claim_req && win_id == IDW'(i + 1)));
  end

endmodule

// File: rtl/irq_claim_arbiter.sv
module irq_claim_arbiter #(
  parameter int NSRC = 31,
  parameter int PW   = 4,
  parameter int IDW  = $clog2(NSRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_pend,
  input  logic [NSRC-1:0]    src_en,
  input  logic [NSRC*PW-1:0] src_prio,
  input  logic [PW-1:0]      ctx_thresh,
  input  logic               claim_req,
  output logic               claim_rsp_valid,
  output logic [IDW-1:0]     claim_rsp_id,
  input  logic               cmpl_req,
  input  logic [IDW-1:0]     cmpl_id,
  output logic               irq
);
  logic [NSRC-1:0] claimed_q;
  logic [NSRC-1:0] above_thr;
  logic [NSRC-1:0] cand;
  logic            win_vld;
  logic [IDW-1:0]  win_id;
  logic [PW-1:0]   win_prio;
  logic            irq_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_thr
    assign above_thr[i] = src_prio[i*PW +: PW] > ctx_thresh;
  end

  assign cand = src_pend & src_en & ~claimed_q & above_thr;

  irq_arb_tree #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) u_tree (
    .cand     (cand),
    .prio     (src_prio),
    .win_vld  (win_vld),
    .win_id   (win_id),
    .win_prio (win_prio)
  );

  irq_claim_track #(.NSRC(NSRC), .IDW(IDW)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .claim_req (claim_req),
    .win_id    (win_id),
    .cmpl_req  (cmpl_req),
    .cmpl_id   (cmpl_id),
    .src_en    (src_en),
    .claimed_q (claimed_q),
    .rsp_valid (claim_rsp_valid),
    .rsp_id    (claim_rsp_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= win_vld;
  end
  assign irq = irq_q;

  a_r1_win_above_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> (win_prio > ctx_thresh));
  a_r1_win_not_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> !claimed_q[win_id - IDW'(1)]);
  a_r1_win_pending: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> (src_pend[win_id - IDW'(1)] && src_en[win_id - IDW'(1)]));
  a_r7_irq_lags_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |=> !irq);

endmodule

// File: tb/tb_irq_claim_arbiter.sv
module tb_irq_claim_arbiter;
  localparam int NSRC = 31;
  localparam int PW   = 4;
  localparam int IDW  = 5;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] src_pend = '0, src_en = '0;
  logic [NSRC*PW-1:0] src_prio = '0;
  logic [PW-1:0] ctx_thresh = '0;
  logic claim_req = 1'b0, cmpl_req = 1'b0;
  logic [IDW-1:0] cmpl_id = '0;
  logic claim_rsp_valid, irq;
  logic [IDW-1:0] claim_rsp_id;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  irq_claim_arbiter #(.NSRC(NSRC), .PW(PW), .IDW(IDW)) dut (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend), .src_en(src_en),
    .src_prio(src_prio), .ctx_thresh(ctx_thresh), .claim_req(claim_req),
    .claim_rsp_valid(claim_rsp_valid), .claim_rsp_id(claim_rsp_id),
    .cmpl_req(cmpl_req), .cmpl_id(cmpl_id), .irq(irq));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_src(input int id, input bit p, input bit e, input int pr);
    src_pend[id-1] = p;
    src_en[id-1]   = e;
    src_prio[(id-1)*PW +: PW] = PW'(pr);
  endtask

  // Claim pulse; response checked in the cycle after the request.
  task automatic claim(input string req, input int exp_id);
    @(negedge clk); claim_req = 1'b1;
    @(negedge clk); claim_req = 1'b0;
    check({req, " rsp_valid"}, int'(claim_rsp_valid), 1);
    check({req, " rsp_id"}, int'(claim_rsp_id), exp_id);
  endtask

  task automatic complete(input int id);
    @(negedge clk); cmpl_req = 1'b1; cmpl_id = IDW'(id);
    @(negedge clk); cmpl_req = 1'b0; cmpl_id = '0;
  endtask

  task automatic irq_is(input string req, input int exp);
    @(negedge clk); @(negedge clk);
    check({req, " irq"}, int'(irq), exp);
  endtask

  task automatic clear_all();
    @(negedge clk);
    src_pend = '0; src_en = '1; src_prio = '0; ctx_thresh = '0;
    for (int i = 1; i <= NSRC; i++) complete(i);
  endtask

  task automatic t_reset();
    check("R9 irq", int'(irq), 0);
    check("R9 rsp_valid", int'(claim_rsp_valid), 0);
    claim("R9 empty claim", 0);
  endtask

  task automatic t_tie_and_repeat();
    @(negedge clk);
    set_src(2, 1, 1, 2); set_src(3, 1, 1, 5); set_src(7, 1, 1, 5);
    irq_is("R7 pending", 1);
    claim("R2 tie lower id", 3);
    claim("R4 next best", 7);
    claim("R4 lower prio", 2);
    claim("R4 exhausted", 0);
    irq_is("R4 all claimed", 0);
    complete(7);
    irq_is("R5 release", 1);
    claim("R5 released id back", 7);
    complete(2); complete(3); complete(7);
    clear_all();
  endtask

  task automatic t_threshold();
    @(negedge clk);
    set_src(2, 1, 1, 2); set_src(3, 1, 1, 5); set_src(9, 1, 1, 0);
    ctx_thresh = 4'd5;
    irq_is("R1 equal to threshold masked", 0);
    claim("R1 masked claim", 0);
    @(negedge clk); ctx_thresh = 4'd4;
    irq_is("R1 threshold lowered", 1);
    claim("R1 above threshold", 3);
    @(negedge clk); ctx_thresh = 4'd0; set_src(2, 0, 1, 2);
    irq_is("R1 prio zero never", 0);
    complete(3);
    clear_all();
  endtask

  task automatic t_highest();
    @(negedge clk);
    set_src(1, 1, 1, 3); set_src(20, 1, 1, 9); set_src(31, 1, 1, 15);
    claim("R2 highest id31", 31);
    claim("R2 then id20", 20);
    claim("R2 then id1", 1);
    clear_all();
  endtask

  task automatic t_disabled_complete();
    @(negedge clk);
    set_src(5, 1, 1, 6); set_src(6, 1, 1, 4);
    claim("R4 claim 5", 5);
    @(negedge clk); src_en[4] = 1'b0;
    complete(5);
    @(negedge clk); src_en[4] = 1'b1;
    claim("R5 disabled complete ignored", 6);
    claim("R6 still claimed", 0);
    complete(0);
    claim("R5 id0 complete ignored", 0);
    complete(5);
    claim("R5 enabled complete", 5);
    clear_all();
  endtask

  task automatic t_latency();
    @(negedge clk);
    set_src(12, 1, 1, 7);
    #1 check("R7 not yet", int'(irq), 0);
    @(negedge clk);
    check("R7 one clock", int'(irq), 1);
    src_pend[11] = 1'b0;
    @(negedge clk);
    check("R7 drop one clock", int'(irq), 0);
    clear_all();
  endtask

  task automatic t_simultaneous();
    @(negedge clk);
    set_src(4, 1, 1, 8); set_src(8, 1, 1, 3);
    claim("R8 first claim", 4);
    @(negedge clk); claim_req = 1'b1; cmpl_req = 1'b1; cmpl_id = 5'd4;
    @(negedge clk); claim_req = 1'b0; cmpl_req = 1'b0; cmpl_id = '0;
    check("R8 claim with complete", int'(claim_rsp_id), 8);
    claim("R8 complete took effect", 4);
    claim("R8 claim took effect", 0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tie_and_repeat();
    t_threshold();
    t_highest();
    t_disabled_complete();
    t_latency();
    t_simultaneous();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule